// File: doc/BRIEF.md
# I2C Master Serial Clock Generator

This block derives the serial clock of an I2C master from a faster peripheral clock. One 16-bit divider word sets the two halves of the SCL period separately. The upper byte sets the high phase and the lower byte sets the low phase. Each phase lasts its byte value plus two peripheral clocks. For example, 0x3333 gives a symmetric period of 106 clocks, and 0x0A0F gives a shorter period with an asymmetric duty cycle.

The line is driven open-drain. The block only ever pulls SCL low, and it reads the real line level back through `scl_in`. While the block has released the line and a slave still holds it low, the high-phase count stands still, so clock stretching lengthens the high phase. Three single-cycle strobes let a byte engine keep step with the clock:
- one when the block pulls the line low, which is the moment to change data;
- one when the block releases the line;
- one at the middle of the counted high time, which is the moment to sample data.

A new divider word is picked up only when a phase begins, so a phase that is running is never cut short or stretched by a register write. Dropping the enable releases the line at once. The next enable always starts with a full low phase.

Top module: `i2c_scl_gen`

## Requirements
- R1: While reset is active or `en` is low, `scl_drive_low` is 0 and all three strobes are 0.
- R2: After `en` rises, the next clock edge starts a low phase: `scl_drive_low` becomes 1 and `fall_stb` is 1 in that first low cycle.
- R3: A low phase lasts exactly 2 + DIVL clock cycles, where DIVL is `div_word[7:0]` as sampled when the phase began.
- R4: Without stretching, a high phase lasts exactly 2 + DIVH clock cycles, where DIVH is `div_word[15:8]` as sampled when the phase began.
- R5: `rise_stb` is 1 in the first cycle of each high phase, and only there.
- R6: `mid_stb` is 1 exactly once per high phase. It appears in the counted high cycle with index floor((DIVH+2)/2), counting from 0, and only while `scl_in` is 1.
- R7: During a high phase, a cycle with `scl_in` at 0 does not advance the high count, so the high phase grows by one cycle for each stretched cycle.
- R8: A change of `div_word` in the middle of a phase leaves that phase's length unchanged. The next phase of each kind uses the new value.
- R9: The three strobes are mutually exclusive, and `fall_stb` never lasts two cycles in a row.
- R10: Deasserting `en` in the middle of a phase releases the line on the next clock edge. A later enable begins with a full low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| div_word | input | 16 | Divider word: high-phase byte in [15:8], low-phase byte in [7:0] |
| en | input | 1 | Clock generation enable |
| scl_in | input | 1 | Sensed SCL line level, already synchronised to `clk` |
| scl_drive_low | output | 1 | 1 = pull SCL low, 0 = release the line |
| rise_stb | output | 1 | One-cycle pulse in the first cycle of a high phase |
| fall_stb | output | 1 | One-cycle pulse in the first cycle of a low phase |
| mid_stb | output | 1 | One-cycle pulse at the middle of the counted high time |

## Verification
The assertions check the following on every cycle:
- the strobes never overlap;
- a disabled block releases the line and stays silent;
- every pull-down comes with a falling strobe, and every release made while enabled comes with a rising strobe;
- a stretched cycle never ends the high phase;
- the mid strobe appears only while the line is really high.

Only the bench's scenarios can show the exact phase lengths for each divider field and the position of the mid strobe. The same holds for the length added by a slave's stretching, the moment a rewritten divider word takes hold, and the full low phase after a re-enable.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;
endpackage

// File: rtl/scl_rst_sync.sv
module scl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/scl_div_hold.sv
module scl_div_hold #(
  parameter int DIV_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*DIV_W-1:0] div_word,
  input  logic               load_low,
  input  logic               load_high,
  output logic [DIV_W-1:0]   lim_low,
  output logic [DIV_W-1:0]   lim_high
);
  logic [DIV_W-1:0] low_q, high_q;

  // Each field is captured only when its own phase starts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= '0;
      high_q <= '0;
    end else begin
      if (load_low)  low_q  <= div_word[DIV_W-1:0];
      if (load_high) high_q <= div_word[2*DIV_W-1:DIV_W];
    end
  end

  assign lim_low  = low_q;
  assign lim_high = high_q;
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_gen_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             scl_in,
  input  logic [DIV_W-1:0] lim_low,
  input  logic [DIV_W-1:0] lim_high,
  output scl_phase_e       phase,
  output logic [CNT_W-1:0] cnt,
  output logic             first,
  output logic             load_low,
  output logic             load_high
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  scl_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             first_q, first_d;
  logic [CNT_W-1:0] low_end, high_end;

  // A phase of 2 + N cycles counts from 0 up to N + 1
  assign low_end  = CNT_W'(lim_low)  + CNT_ONE;
  assign high_end = CNT_W'(lim_high) + CNT_ONE;

  always_comb begin
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    first_d   = 1'b0;
    load_low  = 1'b0;
    load_high = 1'b0;
    if (!en) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          phase_d  = PH_LOW;
          cnt_d    = '0;
          first_d  = 1'b1;
          load_low = 1'b1;
        end
        PH_LOW: begin
          if (cnt_q == low_end) begin
            phase_d   = PH_HIGH;
            cnt_d     = '0;
            first_d   = 1'b1;
            load_high = 1'b1;
          end else begin
            cnt_d = cnt_q + CNT_ONE;
          end
        end
        PH_HIGH: begin
          // The count holds while a slave stretches the line
          if (scl_in) begin
            if (cnt_q == high_end) begin
              phase_d  = PH_LOW;
              cnt_d    = '0;
              first_d  = 1'b1;
              load_low = 1'b1;
            end else begin
              cnt_d = cnt_q + CNT_ONE;
            end
          end
        end
        default: begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      first_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      first_q <= first_d;
    end
  end

  assign phase = phase_q;
  assign cnt   = cnt_q;
  assign first = first_q;
endmodule

// File: rtl/scl_strobe_gen.sv
module scl_strobe_gen
  import scl_gen_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = DIV_W + 1
) (
  input  scl_phase_e       phase,
  input  logic [CNT_W-1:0] cnt,
  input  logic             first,
  input  logic             scl_in,
  input  logic [DIV_W-1:0] lim_high,
  output logic             drive_low,
  output logic             rise_stb,
  output logic             fall_stb,
  output logic             mid_stb
);
  logic [CNT_W-1:0] mid_pt;

  // Half of the (2 + DIVH) counted high cycles
  assign mid_pt = (CNT_W'(lim_high) + CNT_W'(2)) >> 1;

  always_comb begin
    drive_low = (phase == PH_LOW);
    fall_stb  = (phase == PH_LOW)  && first;
    rise_stb  = (phase == PH_HIGH) && first;
    mid_stb   = (phase == PH_HIGH) && scl_in && (cnt == mid_pt);
  end
endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen
  import scl_gen_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*DIV_W-1:0] div_word,
  input  logic               en,
  input  logic               scl_in,
  output logic               scl_drive_low,
  output logic               rise_stb,
  output logic               fall_stb,
  output logic               mid_stb
);
  localparam int CNT_W = DIV_W + 1;

  logic             rst_n_s;
  logic             load_low, load_high;
  logic [DIV_W-1:0] lim_low, lim_high;
  scl_phase_e       phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             first_q;

  scl_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_s)
  );

  scl_div_hold #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .div_word  (div_word),
    .load_low  (load_low),
    .load_high (load_high),
    .lim_low   (lim_low),
    .lim_high  (lim_high)
  );

  scl_phase_fsm #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .en        (en),
    .scl_in    (scl_in),
    .lim_low   (lim_low),
    .lim_high  (lim_high),
    .phase     (phase_q),
    .cnt       (cnt_q),
    .first     (first_q),
    .load_low  (load_low),
    .load_high (load_high)
  );

  scl_strobe_gen #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_stb (
    .phase     (phase_q),
    .cnt       (cnt_q),
    .first     (first_q),
    .scl_in    (scl_in),
    .lim_high  (lim_high),
    .drive_low (scl_drive_low),
    .rise_stb  (rise_stb),
    .fall_stb  (fall_stb),
    .mid_stb   (mid_stb)
  );
endmodule

// File: rtl/i2c_scl_gen_chk.sv
module i2c_scl_gen_chk
  import scl_gen_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       scl_in,
  input logic       scl_drive_low,
  input logic       rise_stb,
  input logic       fall_stb,
  input logic       mid_stb,
  input scl_phase_e phase
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_stb, fall_stb, mid_stb})); // R9

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |=> !fall_stb); // R9

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_drive_low && !rise_stb && !fall_stb && !mid_stb)); // R1

  AST_PULL_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_drive_low) |-> fall_stb); // R2

  AST_RELEASE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_drive_low) && $past(en)) |-> rise_stb); // R5

  AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && phase == PH_HIGH && !scl_in) |=> !scl_drive_low); // R7

  AST_MID_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    mid_stb |-> (!scl_drive_low && scl_in)); // R6
endmodule

bind i2c_scl_gen i2c_scl_gen_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n_s),
  .en            (en),
  .scl_in        (scl_in),
  .scl_drive_low (scl_drive_low),
  .rise_stb      (rise_stb),
  .fall_stb      (fall_stb),
  .mid_stb       (mid_stb),
  .phase         (phase_q)
);

// File: tb/i2c_scl_gen_tb_top.sv
`timescale 1ns/1ps
module i2c_scl_gen_tb_top;
  logic        clk;
  logic        rst_n;
  logic [15:0] div_word;
  logic        en;
  logic        hold;
  logic        scl_in;
  logic        scl_drive_low, rise_stb, fall_stb, mid_stb;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Open-drain line: low if the block or the slave pulls it
  assign scl_in = ~scl_drive_low & ~hold;

  i2c_scl_gen dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .div_word      (div_word),
    .en            (en),
    .scl_in        (scl_in),
    .scl_drive_low (scl_drive_low),
    .rise_stb      (rise_stb),
    .fall_stb      (fall_stb),
    .mid_stb       (mid_stb)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int low_len(logic [15:0] dw);
    return 2 + int'(dw[7:0]);
  endfunction
  function automatic int high_len(logic [15:0] dw);
    return 2 + int'(dw[15:8]);
  endfunction
  function automatic int mid_idx(logic [15:0] dw);
    return (2 + int'(dw[15:8])) / 2;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Entered at the negedge of the first low cycle; returns at the first high cycle
  task automatic check_low(int exp, int new_dw);
    int n = 0;
    chk(fall_stb == 1'b1, "R2 fall_stb at low start", int'(fall_stb), 1);
    while (scl_drive_low && n < 700) begin
      if (n == 1 && new_dw >= 0) div_word = 16'(new_dw);
      n++;
      @(negedge clk);
    end
    chk(n == exp, "R3 low phase length", n, exp);
  endtask

  // Entered at the negedge of the first high cycle; hold already set if stretch > 0
  task automatic check_high(int exp_base, int mid_exp, int stretch);
    int n = 0;
    int mids = 0;
    int mpos = -1;
    chk(rise_stb == 1'b1, "R5 rise_stb at high start", int'(rise_stb), 1);
    while (!scl_drive_low && n < 700) begin
      if (n == stretch) hold = 1'b0;
      #0.5;
      if (mid_stb) begin
        mids++;
        mpos = n;
      end
      if (n > 0 && rise_stb) chk(1'b0, "R5 rise_stb repeated", n, 0);
      n++;
      @(negedge clk);
    end
    hold = 1'b0;
    if (stretch > 0)
      chk(n == exp_base + stretch, "R7 stretched high length", n, exp_base + stretch);
    else
      chk(n == exp_base, "R4 high phase length", n, exp_base);
    chk(mids == 1, "R6 mid_stb count", mids, 1);
    chk(mpos == mid_exp + stretch, "R6 mid_stb position", mpos, mid_exp + stretch);
  endtask

  task automatic start_run(logic [15:0] dw);
    @(negedge clk);
    en = 1'b0;
    div_word = dw;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    chk(scl_drive_low == 1'b1, "R2 low phase after enable", int'(scl_drive_low), 1);
  endtask

  task automatic run_cfg(logic [15:0] dw, int periods, int stretch);
    start_run(dw);
    for (int p = 0; p < periods; p++) begin
      hold = (stretch > 0);
      check_low(low_len(dw), -1);
      check_high(high_len(dw), mid_idx(dw), stretch);
    end
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      summary();
    end
  end

  initial begin : main
    logic [15:0] dw;
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    en = 1'b1;
    hold = 1'b0;
    div_word = 16'h3333;
    repeat (3) @(negedge clk);
    // R1: reset holds the line released even with enable high
    chk(scl_drive_low == 1'b0, "R1 reset line released", int'(scl_drive_low), 0);
    chk({rise_stb, fall_stb, mid_stb} == 3'b000, "R1 reset strobes",
        int'({rise_stb, fall_stb, mid_stb}), 0);
    en = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(scl_drive_low == 1'b0, "R1 disabled line released", int'(scl_drive_low), 0);

    // Directed: standard, fast, minimum, maximum dividers
    run_cfg(16'h3333, 2, 0);
    run_cfg(16'h0A0F, 2, 0);
    run_cfg(16'h0000, 3, 0);
    run_cfg(16'hFFFF, 1, 0);

    // R7: stretching by a slave
    run_cfg(16'h0504, 2, 3);
    run_cfg(16'h0001, 2, 1);

    // R8: rewrite the divider in the middle of a low phase
    start_run(16'h0304);
    check_low(low_len(16'h0304), 16'h0708);
    check_high(high_len(16'h0708), mid_idx(16'h0708), 0);
    chk(1'b1, "R8 new high field used after boundary", 0, 0);
    check_low(low_len(16'h0708), -1);

    // R10: disable in the middle of a high phase, then re-enable
    repeat (2) @(negedge clk);
    chk(scl_drive_low == 1'b0, "R10 in high phase", int'(scl_drive_low), 0);
    en = 1'b0;
    @(negedge clk);
    chk(scl_drive_low == 1'b0 && {rise_stb, fall_stb, mid_stb} == 3'b000,
        "R10 released after disable", int'({scl_drive_low, rise_stb, fall_stb, mid_stb}), 0);
    repeat (3) @(negedge clk);
    chk(scl_drive_low == 1'b0, "R1 stays released while disabled", int'(scl_drive_low), 0);
    div_word = 16'h0206;
    en = 1'b1;
    @(negedge clk);
    chk(scl_drive_low == 1'b1, "R10 re-enable starts low", int'(scl_drive_low), 1);
    check_low(low_len(16'h0206), -1);
    check_high(high_len(16'h0206), mid_idx(16'h0206), 0);

    // R10: disable in the middle of a low phase
    repeat (2) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(scl_drive_low == 1'b0, "R10 released from low phase", int'(scl_drive_low), 0);

    // Random configurations
    for (int i = 0; i < 24; i++) begin
      dw = {8'($urandom % 24), 8'($urandom % 24)};
      run_cfg(dw, 2, int'($urandom % 5));
    end

    done = 1'b1;
    summary();
  end
endmodule